// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block sits between the interrupt lines of a small multiprocessor system and the per-processor interrupt inputs. It samples level-sensitive interrupt lines and holds an enable bit, an 8-bit priority and an 8-bit routing byte for every line. For each processor it drives a vector of lines that are pending, enabled and routed to that processor. Lines 0 to 31 are private to each processor. Lines 0 to 15 of that range are raised by software through a dedicated register, and lines 16 to 31 come from per-processor level inputs. Lines from 32 upward are shared and routed by their routing byte.

All state is reached through a word-wide register bus. Each access carries the index of the processor making it, so that the private range shows each processor its own copy. Reads return data one cycle after the read strobe. A change of state reaches the forwarding outputs one clock after the register that holds it is updated.

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the control word (word address 0x000) gates forwarding. While it is 0, every bit of `cpu_fwd` is 0 one cycle later. The control word reads back with this bit in position 0 and zeros elsewhere.
- R2: The word at 0x001 is read-only. It returns NUM_LINES/32-1 in bits [4:0] and zeros in all other bits, so the line count is (value+1)*32.
- R3: The enable-set words (0x020+w) and enable-clear words (0x040+w) cover 32 lines each, line 32w+b at bit b. A 1 written to a set word enables that line, a 1 written to a clear word disables it, and a 0 bit changes nothing. A read of either word returns the current enable bits.
- R4: Bit c*NUM_LINES+k of `cpu_fwd` is 1 exactly when, in the previous cycle, the control bit was 1 and line k was enabled, pending and routed to processor c. A change of enable or level in the same cycle takes effect together.
- R5: The priority words (0x100+w) hold one byte per line. Line k sits at byte k%4 (bits 8*(k%4)+7 down to 8*(k%4)) of word k/4, and each byte reads back as written.
- R6: The routing words (0x200+w) hold one byte per line, four per word in the priority layout. For a shared line, bit c of its byte routes it to processor c. Words 0 to 7 (lines 0 to 31) ignore writes and return the byte 1<<bus_cpu in each of their four byte lanes.
- R7: The configuration words (0x080+w) hold 2 bits per line, 16 lines per word. Words 0 and 1 (lines 0 to 31) read as zero and ignore writes. The other words in range read back as written. No value alters the level-sensitive behaviour.
- R8: The enable bits of lines 0 to 31 exist once per processor. Enable word 0 and pending word 0 act on the copy selected by `bus_cpu`.
- R9: A write to the software-interrupt word (0x003) sets the pending bit of line wdata[3:0] on every processor c for which wdata[16+c] is 1. This word always reads as zero.
- R10: Pending word 0 (0x060) reads {private level lines 31..16, software lines 15..0} of the accessing processor. A 1 written to bit j (j<16) clears that processor's software pending bit j. Pending word w>0 reads the shared levels of lines 32w to 32w+31, and writes to these words have no effect.
- R11: An access to an address outside every region, or to a word beyond NUM_LINES in any array, reads as zero and changes no state.
- R12: The pending state of a shared line and of a private level line follows its input, one register stage later. `shared_lvl[j]` is line 32+j and `priv_lvl[c*16+j]` is line 16+j of processor c.
- R13: After reset the control bit, all enables, software pending bits and routing bytes are 0, `bus_rdata` is 0 and `cpu_fwd` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | CPU_W | Index of the processor making the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data on `bus_rdata` next cycle |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held until the next read |
| shared_lvl | input | NUM_LINES-32 | Level inputs of shared lines 32 and up |
| priv_lvl | input | NUM_CPUS*16 | Level inputs of private lines 16..31, 16 per processor |
| cpu_fwd | output | NUM_CPUS*NUM_LINES | Forwarded line vector, NUM_LINES bits per processor |

## Verification
A shared level line can rise in the same cycle in which a bus write clears or sets its enable bit. Both edges are registered together, so the forwarding output must follow the enable value that was written and never show a one-cycle glitch from the old enable. The bench drives the level input and the write strobe on the same falling edge. It then checks the routed processor's output bit in the two following cycles: it must stay low in both for the clear case, and go high only in the second for the set case. The random phase mixes level changes with enable, routing and software-interrupt writes, and compares every output vector against a model.

// File: rtl/idist_pkg.sv
`timescale 1ns/1ps
package idist_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_SWI, RG_ENSET, RG_ENCLR,
    RG_PEND, RG_CFG, RG_PRIO, RG_TGT
  } region_e;

  typedef enum logic [1:0] {SRC_FLOP, SRC_PRIO, SRC_CFG} rsrc_e;

  typedef struct packed {
    region_e    rg;
    logic [7:0] idx;
  } decode_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 10'h000;
  localparam logic [ADDR_W-1:0] A_TYPE = 10'h001;
  localparam logic [ADDR_W-1:0] A_SWI  = 10'h003;

  // Region bases: 0x020 set, 0x040 clear, 0x060 pending, 0x080 config,
  // 0x100 priority, 0x200 routing.
  function automatic decode_t decode(input logic [ADDR_W-1:0] a);
    decode_t d;
    d.rg  = RG_NONE;
    d.idx = a[7:0];
    if (a == A_CTRL)            d.rg = RG_CTRL;
    else if (a == A_TYPE)       d.rg = RG_TYPE;
    else if (a == A_SWI)        d.rg = RG_SWI;
    else if (a[9:5] == 5'b00001) begin d.rg = RG_ENSET; d.idx = {3'b0, a[4:0]}; end
    else if (a[9:5] == 5'b00010) begin d.rg = RG_ENCLR; d.idx = {3'b0, a[4:0]}; end
    else if (a[9:5] == 5'b00011) begin d.rg = RG_PEND;  d.idx = {3'b0, a[4:0]}; end
    else if (a[9:6] == 4'b0010)  begin d.rg = RG_CFG;   d.idx = {2'b0, a[5:0]}; end
    else if (a[9:8] == 2'b01)    d.rg = RG_PRIO;
    else if (a[9:8] == 2'b10)    d.rg = RG_TGT;
    return d;
  endfunction
endpackage

// File: rtl/idist_wordmem.sv
`timescale 1ns/1ps
module idist_wordmem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/idist_fwd.sv
`timescale 1ns/1ps
module idist_fwd #(
  parameter int LINES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en,
  input  logic [LINES-1:0] en_vec,
  input  logic [LINES-1:0] pend_vec,
  input  logic [LINES-1:0] tgt_vec,
  output logic [LINES-1:0] fwd
);
  always_ff @(posedge clk) begin
    if (rst) fwd <= '0;
    else     fwd <= ctrl_en ? (en_vec & pend_vec & tgt_vec) : '0;
  end

  // R1
  fwd_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (fwd == '0));

  // R4
  fwd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((fwd & ~$past(en_vec & pend_vec & tgt_vec)) == '0));

  // R4
  fwd_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && |(en_vec & pend_vec & tgt_vec)) |=> (fwd != '0));
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
module irq_distributor import idist_pkg::*; #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 64,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int NSH   = NUM_LINES - 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CPU_W-1:0]              bus_cpu,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NSH-1:0]                shared_lvl,
  input  logic [NUM_CPUS*16-1:0]        priv_lvl,
  output logic [NUM_CPUS*NUM_LINES-1:0] cpu_fwd
);
  localparam int EN_WORDS   = NUM_LINES / 32;
  localparam int PRIO_WORDS = NUM_LINES / 4;
  localparam int CFG_WORDS  = NUM_LINES / 16;
  localparam int PRIV_TGT_W = 8;
  localparam int PRIV_CFG_W = 2;
  localparam int PAW = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;
  localparam int CAW = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

  decode_t dec;
  assign dec = decode(bus_addr);

  logic            ctrl_en;
  logic [31:0]     en_priv  [NUM_CPUS];
  logic [15:0]     swi_pend [NUM_CPUS];
  logic [15:0]     plvl_q   [NUM_CPUS];
  logic [NSH-1:0]  en_sh;
  logic [NSH-1:0]  pend_sh;
  logic [NSH*8-1:0] tgt_sh;

  // Index checks shared by the write and read paths
  logic en_ok, tgt_ok, prio_ok, cfg_ok;
  int   sw, tw;
  always_comb begin
    en_ok   = (dec.idx != 8'd0) && (int'(dec.idx) < EN_WORDS);
    sw      = en_ok ? int'(dec.idx) - 1 : 0;
    tgt_ok  = (int'(dec.idx) >= PRIV_TGT_W) && (int'(dec.idx) < PRIO_WORDS);
    tw      = tgt_ok ? int'(dec.idx) - PRIV_TGT_W : 0;
    prio_ok = int'(dec.idx) < PRIO_WORDS;
    cfg_ok  = (int'(dec.idx) >= PRIV_CFG_W) && (int'(dec.idx) < CFG_WORDS);
  end

  // State updates
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      en_sh   <= '0;
      pend_sh <= '0;
      tgt_sh  <= '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
        en_priv[c]  <= '0;
        swi_pend[c] <= '0;
        plvl_q[c]   <= '0;
      end
    end else begin
      pend_sh <= shared_lvl;
      for (int c = 0; c < NUM_CPUS; c++) plvl_q[c] <= priv_lvl[c*16 +: 16];
      if (bus_wr) begin
        case (dec.rg)
          RG_CTRL: ctrl_en <= bus_wdata[0];
          RG_ENSET: begin
            if (dec.idx == 8'd0) en_priv[bus_cpu] <= en_priv[bus_cpu] | bus_wdata;
            else if (en_ok)      en_sh[sw*32 +: 32] <= en_sh[sw*32 +: 32] | bus_wdata;
          end
          RG_ENCLR: begin
            if (dec.idx == 8'd0) en_priv[bus_cpu] <= en_priv[bus_cpu] & ~bus_wdata;
            else if (en_ok)      en_sh[sw*32 +: 32] <= en_sh[sw*32 +: 32] & ~bus_wdata;
          end
          RG_PEND: begin
            if (dec.idx == 8'd0) swi_pend[bus_cpu] <= swi_pend[bus_cpu] & ~bus_wdata[15:0];
          end
          RG_SWI: begin
            for (int c = 0; c < NUM_CPUS; c++)
              if (bus_wdata[16+c]) swi_pend[c][bus_wdata[3:0]] <= 1'b1;
          end
          RG_TGT: if (tgt_ok) tgt_sh[tw*32 +: 32] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // Priority and configuration arrays in inferable RAM
  logic [31:0] prio_rd, cfg_rd;
  idist_wordmem #(.DEPTH(PRIO_WORDS), .WIDTH(32)) u_prio (
    .clk   (clk),
    .we    (bus_wr && dec.rg == RG_PRIO && prio_ok),
    .waddr (dec.idx[PAW-1:0]),
    .wdata (bus_wdata),
    .re    (bus_rd && dec.rg == RG_PRIO && prio_ok),
    .raddr (dec.idx[PAW-1:0]),
    .rdata (prio_rd)
  );
  idist_wordmem #(.DEPTH(CFG_WORDS), .WIDTH(32)) u_cfg (
    .clk   (clk),
    .we    (bus_wr && dec.rg == RG_CFG && cfg_ok),
    .waddr (dec.idx[CAW-1:0]),
    .wdata (bus_wdata),
    .re    (bus_rd && dec.rg == RG_CFG && cfg_ok),
    .raddr (dec.idx[CAW-1:0]),
    .rdata (cfg_rd)
  );

  // Read path
  logic [31:0] rd_val, rd_q;
  rsrc_e       rd_src, src_q;
  logic [7:0]  own_byte;
  assign own_byte = 8'd1 << bus_cpu;

  always_comb begin
    rd_val = '0;
    rd_src = SRC_FLOP;
    case (dec.rg)
      RG_CTRL: rd_val = {31'b0, ctrl_en};
      RG_TYPE: rd_val = 32'(EN_WORDS - 1);
      RG_ENSET, RG_ENCLR: begin
        if (dec.idx == 8'd0) rd_val = en_priv[bus_cpu];
        else if (en_ok)      rd_val = en_sh[sw*32 +: 32];
      end
      RG_PEND: begin
        if (dec.idx == 8'd0) rd_val = {plvl_q[bus_cpu], swi_pend[bus_cpu]};
        else if (en_ok)      rd_val = pend_sh[sw*32 +: 32];
      end
      RG_TGT: begin
        if (int'(dec.idx) < PRIV_TGT_W) rd_val = {4{own_byte}};
        else if (tgt_ok)                rd_val = tgt_sh[tw*32 +: 32];
      end
      RG_PRIO: if (prio_ok) rd_src = SRC_PRIO;
      RG_CFG:  if (cfg_ok)  rd_src = SRC_CFG;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      src_q <= SRC_FLOP;
    end else if (bus_rd) begin
      rd_q  <= rd_val;
      src_q <= rd_src;
    end
  end

  assign bus_rdata = (src_q == SRC_PRIO) ? prio_rd :
                     (src_q == SRC_CFG)  ? cfg_rd  : rd_q;

  // Per-processor forwarding
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_LINES-1:0] en_v, pend_v, tgt_v;
    assign en_v   = {en_sh, en_priv[c]};
    assign pend_v = {pend_sh, plvl_q[c], swi_pend[c]};
    assign tgt_v[31:0] = '1;
    for (genvar l = 0; l < NSH; l++) begin : g_tgt
      assign tgt_v[32+l] = tgt_sh[l*8 + c];
    end
    idist_fwd #(.LINES(NUM_LINES)) u_fwd (
      .clk      (clk),
      .rst      (rst),
      .ctrl_en  (ctrl_en),
      .en_vec   (en_v),
      .pend_vec (pend_v),
      .tgt_vec  (tgt_v),
      .fwd      (cpu_fwd[c*NUM_LINES +: NUM_LINES])
    );
  end

  // R9
  swi_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec.rg == RG_SWI && bus_wdata[16]) |=> swi_pend[0][$past(bus_wdata[3:0])]);

  // R3
  enclr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec.rg == RG_ENCLR && dec.idx == 8'd0 && bus_cpu == '0)
      |=> ((en_priv[0] & $past(bus_wdata)) == '0));

  // R11
  oor_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dec.rg == RG_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_distributor_tb.sv
`timescale 1ns/1ps
module irq_distributor_tb;
  localparam int NC  = 2;
  localparam int NL  = 64;
  localparam int NSH = NL - 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [0:0]        bus_cpu = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [9:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NSH-1:0]    shl = '0;
  logic [NC*16-1:0]  pl = '0;
  logic [NC*NL-1:0]  cpu_fwd;

  always #2.5 clk = ~clk;

  irq_distributor #(.NUM_CPUS(NC), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shared_lvl(shl), .priv_lvl(pl), .cpu_fwd(cpu_fwd)
  );

  int n_chk = 0;
  int n_err = 0;

  // Bench model
  logic        m_ctrl;
  logic [31:0] m_enp [NC];
  logic [31:0] m_ens;
  logic [15:0] m_swi [NC];
  logic [7:0]  m_tgt [NSH];
  logic [31:0] m_prio [NL/4];
  logic [31:0] m_cfg [NL/16];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void mwr(int cpu, int a, logic [31:0] d);
    if (a == 0) m_ctrl = d[0];
    else if (a == 3) begin
      for (int c = 0; c < NC; c++) if (d[16+c]) m_swi[c][d[3:0]] = 1'b1;
    end
    else if (a == 'h020) m_enp[cpu] |= d;
    else if (a == 'h021) m_ens |= d;
    else if (a == 'h040) m_enp[cpu] &= ~d;
    else if (a == 'h041) m_ens &= ~d;
    else if (a == 'h060) m_swi[cpu] &= ~d[15:0];
    else if (a >= 'h082 && a < 'h080 + NL/16) m_cfg[a - 'h080] = d;
    else if (a >= 'h100 && a < 'h100 + NL/4) m_prio[a - 'h100] = d;
    else if (a >= 'h208 && a < 'h200 + NL/4)
      for (int b = 0; b < 4; b++) m_tgt[(a - 'h208)*4 + b] = d[8*b +: 8];
  endfunction

  function automatic logic [31:0] mrd(int cpu, int a);
    logic [7:0] own;
    own = 8'd1 << cpu;
    if (a == 0) return {31'b0, m_ctrl};
    if (a == 1) return 32'(NL/32 - 1);
    if (a == 'h020 || a == 'h040) return m_enp[cpu];
    if (a == 'h021 || a == 'h041) return m_ens;
    if (a == 'h060) return {pl[cpu*16 +: 16], m_swi[cpu]};
    if (a == 'h061) return shl;
    if (a >= 'h082 && a < 'h080 + NL/16) return m_cfg[a - 'h080];
    if (a >= 'h100 && a < 'h100 + NL/4) return m_prio[a - 'h100];
    if (a >= 'h200 && a < 'h208) return {4{own}};
    if (a >= 'h208 && a < 'h200 + NL/4)
      return {m_tgt[(a-'h208)*4+3], m_tgt[(a-'h208)*4+2], m_tgt[(a-'h208)*4+1], m_tgt[(a-'h208)*4]};
    return 32'd0;
  endfunction

  function automatic logic [63:0] exp_fwd(int c);
    logic [63:0] v;
    for (int l = 0; l < NL; l++) begin
      logic en, pd, tg;
      en = (l < 32) ? m_enp[c][l] : m_ens[l-32];
      pd = (l < 16) ? m_swi[c][l] : (l < 32) ? pl[c*16 + l - 16] : shl[l-32];
      tg = (l < 32) ? 1'b1 : m_tgt[l-32][c];
      v[l] = m_ctrl & en & pd & tg;
    end
    return v;
  endfunction

  task automatic wr(int cpu, int a, logic [31:0] d);
    @(negedge clk);
    bus_cpu = 1'(cpu); bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
    mwr(cpu, a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int cpu, int a, output logic [31:0] d);
    @(negedge clk);
    bus_cpu = 1'(cpu); bus_addr = 10'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(string tag, int cpu, int a);
    logic [31:0] d;
    rd(cpu, a, d);
    chk(tag, 64'(d), 64'(mrd(cpu, a)));
  endtask

  task automatic set_lvl(logic [NSH-1:0] s, logic [NC*16-1:0] p);
    @(negedge clk);
    shl = s; pl = p;
    @(negedge clk);
  endtask

  task automatic check_fwd(string tag);
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk(tag, cpu_fwd[c*NL +: NL], exp_fwd(c));
  endtask

  logic done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    m_ctrl = 1'b0; m_ens = '0;
    for (int c = 0; c < NC; c++) begin m_enp[c] = '0; m_swi[c] = '0; end
    for (int i = 0; i < NSH; i++) m_tgt[i] = '0;
    for (int i = 0; i < NL/4; i++) m_prio[i] = '0;
    for (int i = 0; i < NL/16; i++) m_cfg[i] = '0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 rdata after reset", 64'(bus_rdata), 64'd0);
    chk("R13 fwd after reset", 64'(cpu_fwd[NC*NL-1:NL]), 64'd0);
    chk("R13 fwd after reset", 64'(cpu_fwd[NL-1:0]), 64'd0);
    rdchk("R13 ctrl reset", 0, 'h000);
    rdchk("R13 enable reset", 1, 'h021);
    rdchk("R13 routing reset", 0, 'h20C);

    // R2 type word, write ignored
    wr(0, 'h001, 32'hFFFF_FFFF);
    rdchk("R2 type word", 0, 'h001);

    // R5 priority placement and readback
    for (int i = 0; i < NL/4; i++) wr(0, 'h100 + i, $urandom);
    for (int i = 0; i < NL/4; i++) rdchk("R5 priority readback", i % NC, 'h100 + i);
    wr(1, 'h105, 32'h4433_2211);
    rd(0, 'h105, d);
    chk("R5 line 22 in byte 2", 64'(d[8*(22%4) +: 8]), 64'h33);

    // R6 private routing read-only per processor
    wr(0, 'h200, 32'hFFFF_FFFF);
    rdchk("R6 private routing cpu0", 0, 'h200);
    rdchk("R6 private routing cpu1", 1, 'h207);
    rd(1, 'h200, d);
    chk("R6 private routing value", 64'(d), 64'h0202_0202);

    // R7 configuration
    wr(0, 'h080, 32'hAAAA_AAAA);
    rdchk("R7 private config zero", 0, 'h080);
    wr(0, 'h082, 32'h5A5A_1234);
    rdchk("R7 shared config", 1, 'h082);

    // R11 out of range
    wr(0, 'h110, 32'hDEAD_BEEF);
    rdchk("R11 priority beyond lines", 0, 'h110);
    rdchk("R11 priority array intact", 0, 'h100);
    wr(0, 'h022, 32'hFFFF_FFFF);
    rdchk("R11 enable beyond lines", 0, 'h022);
    rdchk("R11 shared enable untouched", 0, 'h021);
    rdchk("R11 unmapped", 0, 'h300);
    rdchk("R11 routing beyond lines", 0, 'h210);

    // R3 set/clear semantics
    wr(0, 'h020, 32'h0000_F0F0);
    wr(0, 'h020, 32'h0000_0FF0);
    rdchk("R3 set read via set word", 0, 'h020);
    wr(0, 'h040, 32'h0);
    rdchk("R3 zero clear no effect", 0, 'h040);
    wr(0, 'h040, 32'h0000_00F0);
    rdchk("R3 clear read via clear word", 0, 'h040);
    // R8 banking
    rdchk("R8 cpu1 private enables", 1, 'h020);
    wr(1, 'h020, 32'h0001_0020);
    rdchk("R8 cpu0 copy unchanged", 0, 'h020);

    // R9 software interrupt
    wr(0, 'h003, 32'h0002_0005);
    rdchk("R9 pending on cpu1", 1, 'h060);
    rdchk("R9 no pending on cpu0", 0, 'h060);
    rdchk("R9 swi word reads zero", 0, 'h003);
    // R10 pending clear
    wr(0, 'h060, 32'h0000_0020);
    rdchk("R10 clear other cpu no effect", 1, 'h060);
    wr(1, 'h060, 32'h0000_0020);
    rdchk("R10 cleared", 1, 'h060);
    set_lvl(32'h8000_0001, 32'h0003_8000);
    rdchk("R12 private level pending", 1, 'h060);
    rdchk("R12 shared level pending", 0, 'h061);
    wr(0, 'h061, 32'hFFFF_FFFF);
    rdchk("R10 level pending not cleared", 0, 'h061);

    // R1 gating with everything pending
    wr(0, 'h021, 32'hFFFF_FFFF);
    wr(0, 'h208, 32'h0303_0303);
    check_fwd("R1 control off gates all");
    wr(0, 'h000, 32'h1);
    check_fwd("R4 forward with control on");
    rdchk("R1 control readback", 0, 'h000);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 9);
      case (op)
        0: wr(int'($urandom % NC), 'h020 + int'($urandom % 2), $urandom);
        1: wr(int'($urandom % NC), 'h040 + int'($urandom % 2), $urandom);
        2: wr(0, 'h208 + int'($urandom % (NL/4 - 8)), $urandom);
        3: wr(int'($urandom % NC), 'h003, $urandom);
        4: wr(int'($urandom % NC), 'h060, $urandom);
        5: set_lvl(NSH'($urandom), (NC*16)'($urandom));
        6: wr(0, 'h000, ($urandom % 4 == 0) ? 32'h0 : 32'h1);
        7: rdchk("R3 random readback", int'($urandom % NC), 'h020 + int'($urandom % 2));
        default: rdchk("R10 random pending read", int'($urandom % NC), 'h060 + int'($urandom % 2));
      endcase
      check_fwd("R4 random forwarding");
    end

    // R4 same-cycle: level rises while enable is cleared
    wr(0, 'h000, 32'h1);
    wr(0, 'h021, 32'h0000_0100);
    wr(0, 'h20A, 32'h0000_0001);
    set_lvl('0, '0);
    check_fwd("R4 line 40 idle");
    @(negedge clk);
    shl[8] = 1'b1;
    bus_cpu = 1'b0; bus_addr = 10'h041; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
    mwr(0, 'h041, 32'h0000_0100);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R4 clear+rise first cycle", 64'(cpu_fwd[40]), 64'd0);
    @(negedge clk);
    chk("R4 clear+rise second cycle", 64'(cpu_fwd[40]), 64'd0);
    chk("R4 clear+rise full vector", cpu_fwd[NL-1:0], exp_fwd(0));
    // R4 same-cycle: level rises while enable is set
    set_lvl('0, pl);
    @(negedge clk);
    shl[8] = 1'b1;
    bus_cpu = 1'b1; bus_addr = 10'h021; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
    mwr(1, 'h021, 32'h0000_0100);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R4 set+rise first cycle", 64'(cpu_fwd[40]), 64'd0);
    @(negedge clk);
    chk("R4 set+rise second cycle", 64'(cpu_fwd[40]), 64'd1);
    chk("R6 line 40 not routed to cpu1", 64'(cpu_fwd[NL+40]), 64'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule